// File: doc/BRIEF.md
# Conversion-Complete DMA Request Generator

This block sits beside a multi-channel converter and turns the end of a channel's conversion into a single DMA request line. Each kind of channel has its own 16-bit selection mask. When a conversion finishes on a channel whose bit is set in the mask for that channel's kind, and DMA is globally enabled, the block raises its request. It also reports which channel and kind hold the data waiting to be moved.

The request is withdrawn in one of two ways. A DMA acknowledge always withdraws it. When the clear-on-read mode is on, a bus read of the waiting channel's data register also withdraws it. If another selected conversion finishes while a request is still waiting, the newer channel replaces the waiting one and an overrun flag is raised. The masks are set up before conversions begin, and the block ignores any mask write made while a conversion is running.

Register encoding on the write port: address 0 is the control word, with bit 0 the DMA enable and bit 1 the clear-on-read mode. Address 1+k holds the mask for channel kind k, and bit i of a mask selects channel i.

Top module: `cdr_dma_requester`

## Requirements
- R1: One cycle after a qualifying conversion-done strobe, `dma_req` is 1, and `req_type` and `req_chan` equal the kind and channel of that strobe. A strobe qualifies when DMA is enabled and bit `conv_chan` of the mask at address 1+`conv_type` is set.
- R2: A conversion on a channel whose bit is clear in its own kind's mask raises no request, even when the same bit is set in another kind's mask.
- R3: While control bit 0 is 0, no request is raised. Writing 0 to control bit 0 while a request is waiting drops `dma_req` and `overrun` one cycle after the enable change takes effect.
- R4: With control bit 1 set, a bus read whose kind and channel both equal the waiting `req_type` and `req_chan` drops `dma_req` on the next cycle. A read of any other channel or kind leaves the request in place.
- R5: A mask write made while `conv_busy` is 1 leaves that mask unchanged. A mask write made while it is 0 takes effect.
- R6: A `dma_ack` pulse drops `dma_req` and `overrun` on the next cycle, in either mode, unless a qualifying strobe arrives in the same cycle.
- R7: With control bit 1 clear, bus reads never withdraw a waiting request.
- R8: A qualifying strobe that arrives while a request is waiting and is not being withdrawn replaces `req_type` and `req_chan` and sets `overrun`. `overrun` is only ever 1 while `dma_req` is 1.
- R9: When a qualifying strobe and a withdrawal fall in the same cycle, the new request wins: `dma_req` stays 1 with the new channel and `overrun` is 0.
- R10: After reset, `dma_req` and `overrun` are 0, all masks are 0, and both control bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 control, 1+k mask of kind k) |
| wr_data | input | 16 | Register write data |
| conv_busy | input | 1 | A conversion is in progress |
| conv_done | input | 1 | End-of-conversion strobe |
| conv_type | input | 1 | Kind of the finished channel |
| conv_chan | input | 4 | Index of the finished channel |
| rd_en | input | 1 | Bus read of a channel data register |
| rd_type | input | 1 | Kind of the channel being read |
| rd_chan | input | 4 | Index of the channel being read |
| dma_ack | input | 1 | DMA acknowledge pulse |
| dma_req | output | 1 | DMA request |
| req_type | output | 1 | Kind of the waiting channel |
| req_chan | output | 4 | Index of the waiting channel |
| overrun | output | 1 | Waiting data was replaced before it was moved |

## Verification
The hardest case to reach is the collision between a new qualifying strobe and a withdrawal in the same cycle, because the new strobe must override the clear. The stimulus first leaves a request waiting, then drives a strobe for a different selected channel together with `dma_ack`. It then checks that the channel changes while `overrun` stays low. The stimulus also reaches a mask write during `conv_busy` by raising busy around the write. The write's lack of effect is then shown at the ports, since a later conversion on the affected channel still raises no request.

// File: rtl/cdr_pkg.sv
package cdr_pkg;

  localparam int unsigned CTRL_ADDR    = 0;
  localparam int unsigned CTRL_EN_BIT  = 0;
  localparam int unsigned CTRL_COR_BIT = 1;

  typedef struct packed {
    logic cor;
    logic en;
  } cdr_ctrl_t;

  // Select one bit of a (zero-extended) vector; out-of-range indices read 0.
  function automatic logic pick_bit(input logic [63:0] vec, input int unsigned idx);
    logic [5:0] sel;
    sel = idx[5:0];
    return (idx < 64) ? vec[sel] : 1'b0;
  endfunction

  // True when two (kind, channel) pairs name the same slot.
  function automatic logic same_slot(input int unsigned ta, input int unsigned ca,
                                     input int unsigned tb, input int unsigned cb);
    return (ta == tb) && (ca == cb);
  endfunction

endpackage

// File: rtl/cdr_cfg_regs.sv
module cdr_cfg_regs
  import cdr_pkg::*;
#(
  parameter int unsigned NUM_TYPES = 2,
  parameter int unsigned CHANS     = 16,
  parameter int unsigned AW        = $clog2(NUM_TYPES + 1)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [AW-1:0]                   wr_addr,
  input  logic [CHANS-1:0]                wr_data,
  input  logic                            conv_busy,
  output cdr_ctrl_t                       ctrl_q,
  output logic [NUM_TYPES-1:0][CHANS-1:0] mask_q
);

  logic ctrl_sel;
  assign ctrl_sel = wr_en && (wr_addr == AW'(CTRL_ADDR));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_sel) begin
      ctrl_q.en  <= wr_data[CTRL_EN_BIT];
      ctrl_q.cor <= wr_data[CTRL_COR_BIT];
    end
  end

  for (genvar t = 0; t < NUM_TYPES; t++) begin : g_mask
    logic mask_sel;
    logic mask_take;
    assign mask_sel  = wr_en && (wr_addr == AW'(t + 1));
    assign mask_take = mask_sel && !conv_busy;

    always_ff @(posedge clk) begin
      if (!rst_n) mask_q[t] <= '0;
      else if (mask_take) mask_q[t] <= wr_data;
    end

    // R5: mask frozen against writes during a conversion
    p_mask_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_sel && conv_busy) |=> $stable(mask_q[t]));
  end

endmodule

// File: rtl/cdr_hit_qual.sv
module cdr_hit_qual
  import cdr_pkg::*;
#(
  parameter int unsigned NUM_TYPES = 2,
  parameter int unsigned CHANS     = 16,
  parameter int unsigned TW        = $clog2(NUM_TYPES),
  parameter int unsigned CW        = $clog2(CHANS)
) (
  input  logic                            en,
  input  logic [NUM_TYPES-1:0][CHANS-1:0] mask,
  input  logic                            conv_done,
  input  logic [TW-1:0]                   conv_type,
  input  logic [CW-1:0]                   conv_chan,
  output logic                            hit
);

  logic [CHANS-1:0] row;

  always_comb begin
    row = '0;
    for (int t = 0; t < NUM_TYPES; t++) begin
      if (int'(conv_type) == t) row = mask[t];
    end
    hit = conv_done && en && pick_bit(64'(row), int'(conv_chan));
  end

endmodule

// File: rtl/cdr_req_track.sv
module cdr_req_track
  import cdr_pkg::*;
#(
  parameter int unsigned TW = 1,
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          cor,
  input  logic          hit,
  input  logic [TW-1:0] conv_type,
  input  logic [CW-1:0] conv_chan,
  input  logic          rd_en,
  input  logic [TW-1:0] rd_type,
  input  logic [CW-1:0] rd_chan,
  input  logic          dma_ack,
  output logic          pend_q,
  output logic [TW-1:0] type_q,
  output logic [CW-1:0] chan_q,
  output logic          ovr_q
);

  logic rd_match;
  logic clr_evt;
  logic ovr_evt;

  assign rd_match = cor && rd_en && pend_q &&
                    same_slot(int'(rd_type), int'(rd_chan), int'(type_q), int'(chan_q));
  assign clr_evt  = dma_ack || !en || rd_match;
  assign ovr_evt  = hit && pend_q && !clr_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      type_q <= '0;
      chan_q <= '0;
      ovr_q  <= 1'b0;
    end else if (hit) begin
      pend_q <= 1'b1;
      type_q <= conv_type;
      chan_q <= conv_chan;
      ovr_q  <= ovr_evt;
    end else if (clr_evt) begin
      pend_q <= 1'b0;
      ovr_q  <= 1'b0;
    end
  end

  // R1: a qualifying conversion is captured on the next cycle
  p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (pend_q && type_q == $past(conv_type) && chan_q == $past(conv_chan)));

  // R6: acknowledge withdraws the request
  p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_ack && !hit) |=> (!pend_q && !ovr_q));

  // R7: without clear-on-read a waiting request survives bus reads
  p_read_no_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !cor && !dma_ack && en && !hit) |=> pend_q);

  // R8: replacement of waiting data flags overrun
  p_overrun_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && pend_q && !dma_ack && en && !rd_en) |=> ovr_q);

  // R9: new strobe beats withdrawal
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && dma_ack) |=> (pend_q && !ovr_q));

endmodule

// File: rtl/cdr_dma_requester.sv
module cdr_dma_requester
  import cdr_pkg::*;
#(
  parameter int unsigned NUM_TYPES = 2,
  parameter int unsigned CHANS     = 16,
  parameter int unsigned TW        = $clog2(NUM_TYPES),
  parameter int unsigned CW        = $clog2(CHANS),
  parameter int unsigned AW        = $clog2(NUM_TYPES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [CHANS-1:0] wr_data,
  input  logic             conv_busy,
  input  logic             conv_done,
  input  logic [TW-1:0]    conv_type,
  input  logic [CW-1:0]    conv_chan,
  input  logic             rd_en,
  input  logic [TW-1:0]    rd_type,
  input  logic [CW-1:0]    rd_chan,
  input  logic             dma_ack,
  output logic             dma_req,
  output logic [TW-1:0]    req_type,
  output logic [CW-1:0]    req_chan,
  output logic             overrun
);

  cdr_ctrl_t                       ctrl_q;
  logic [NUM_TYPES-1:0][CHANS-1:0] mask_q;
  logic                            hit;

  cdr_cfg_regs #(.NUM_TYPES(NUM_TYPES), .CHANS(CHANS), .AW(AW)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .conv_busy (conv_busy),
    .ctrl_q    (ctrl_q),
    .mask_q    (mask_q)
  );

  cdr_hit_qual #(.NUM_TYPES(NUM_TYPES), .CHANS(CHANS), .TW(TW), .CW(CW)) u_qual (
    .en        (ctrl_q.en),
    .mask      (mask_q),
    .conv_done (conv_done),
    .conv_type (conv_type),
    .conv_chan (conv_chan),
    .hit       (hit)
  );

  cdr_req_track #(.TW(TW), .CW(CW)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (ctrl_q.en),
    .cor       (ctrl_q.cor),
    .hit       (hit),
    .conv_type (conv_type),
    .conv_chan (conv_chan),
    .rd_en     (rd_en),
    .rd_type   (rd_type),
    .rd_chan   (rd_chan),
    .dma_ack   (dma_ack),
    .pend_q    (dma_req),
    .type_q    (req_type),
    .chan_q    (req_chan),
    .ovr_q     (overrun)
  );

  // R3: a disabled block holds no request one cycle on
  p_disable_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.en |=> !dma_req);

  // R8: overrun never stands alone
  p_ovr_with_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> dma_req);

  // R2: an unselected channel raises nothing from idle
  p_unmasked_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_req && !hit) |=> !dma_req);

endmodule

// File: tb/cdr_dma_requester_test.sv
module cdr_dma_requester_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        conv_busy = 1'b0;
  logic        conv_done = 1'b0;
  logic [0:0]  conv_type = '0;
  logic [3:0]  conv_chan = '0;
  logic        rd_en = 1'b0;
  logic [0:0]  rd_type = '0;
  logic [3:0]  rd_chan = '0;
  logic        dma_ack = 1'b0;
  logic        dma_req;
  logic [0:0]  req_type;
  logic [3:0]  req_chan;
  logic        overrun;

  always #4 clk = ~clk;

  cdr_dma_requester uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .conv_busy(conv_busy), .conv_done(conv_done), .conv_type(conv_type),
    .conv_chan(conv_chan), .rd_en(rd_en), .rd_type(rd_type), .rd_chan(rd_chan),
    .dma_ack(dma_ack), .dma_req(dma_req), .req_type(req_type), .req_chan(req_chan),
    .overrun(overrun)
  );

  int checks = 0;
  int fails  = 0;
  string phase = "R10";

  // behavioural reference state
  int m_pend = 0, m_type = 0, m_chan = 0, m_ovr = 0, m_en = 0, m_cor = 0;
  int m_mask[2] = '{0, 0};

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got %0d exp %0d", req, what, got, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = 0; m_type = 0; m_chan = 0; m_ovr = 0; m_en = 0; m_cor = 0;
      m_mask[0] = 0; m_mask[1] = 0;
    end else begin
      bit hit_m, clr_m;
      hit_m = conv_done && (m_en != 0) && (((m_mask[int'(conv_type)] >> int'(conv_chan)) & 1) == 1);
      clr_m = dma_ack || (m_en == 0) ||
              ((m_cor != 0) && rd_en && (m_pend != 0) &&
               int'(rd_type) == m_type && int'(rd_chan) == m_chan);
      if (hit_m) begin
        m_ovr  = (m_pend != 0 && !clr_m) ? 1 : 0;
        m_pend = 1;
        m_type = int'(conv_type);
        m_chan = int'(conv_chan);
      end else if (clr_m) begin
        m_pend = 0;
        m_ovr  = 0;
      end
      if (wr_en) begin
        if (wr_addr == 2'd0) begin
          m_en  = int'(wr_data[0]);
          m_cor = int'(wr_data[1]);
        end else if (!conv_busy && wr_addr <= 2'd2) begin
          m_mask[int'(wr_addr) - 1] = int'(wr_data);
        end
      end
    end
  end

  // compare against the model every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(phase, "dma_req", int'(dma_req), m_pend);
      chk(phase, "overrun", int'(overrun), m_ovr);
      if (m_pend != 0) begin
        chk(phase, "req_type", int'(req_type), m_type);
        chk(phase, "req_chan", int'(req_chan), m_chan);
      end
    end
  end

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic conv(input int t, input int c);
    conv_done = 1'b1; conv_type = 1'(t); conv_chan = 4'(c);
    cyc();
    conv_done = 1'b0;
  endtask

  task automatic rd(input int t, input int c);
    rd_en = 1'b1; rd_type = 1'(t); rd_chan = 4'(c);
    cyc();
    rd_en = 1'b0;
  endtask

  task automatic ack();
    dma_ack = 1'b1;
    cyc();
    dma_ack = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired got 1 exp 0");
    finish_run();
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    phase = "R10";
    chk("R10", "dma_req after reset", int'(dma_req), 0);
    chk("R10", "overrun after reset", int'(overrun), 0);

    // R3: masks set, enable still off
    phase = "R3";
    wr(2'd1, 16'h0005);
    wr(2'd2, 16'h8000);
    conv(0, 0);
    chk("R3", "req while disabled", int'(dma_req), 0);

    // R2 and R1
    wr(2'd0, 16'h0001);
    phase = "R2";
    conv(0, 1);
    chk("R2", "req for unselected channel", int'(dma_req), 0);
    conv(1, 0);
    chk("R2", "req for other kind's bit", int'(dma_req), 0);
    phase = "R1";
    conv(1, 15);
    chk("R1", "req raised", int'(dma_req), 1);
    chk("R1", "req_type", int'(req_type), 1);
    chk("R1", "req_chan", int'(req_chan), 15);

    // R7 then R6
    phase = "R7";
    rd(1, 15);
    cyc();
    chk("R7", "req kept after read", int'(dma_req), 1);
    phase = "R6";
    ack();
    chk("R6", "req after ack", int'(dma_req), 0);

    // R8
    phase = "R8";
    conv(0, 0);
    conv(0, 2);
    chk("R8", "overrun", int'(overrun), 1);
    chk("R8", "replaced chan", int'(req_chan), 2);
    ack();
    chk("R8", "overrun after ack", int'(overrun), 0);

    // R9
    phase = "R9";
    conv(0, 0);
    conv_done = 1'b1; conv_type = 1'b0; conv_chan = 4'd2; dma_ack = 1'b1;
    cyc();
    conv_done = 1'b0; dma_ack = 1'b0;
    chk("R9", "req kept", int'(dma_req), 1);
    chk("R9", "chan", int'(req_chan), 2);
    chk("R9", "overrun", int'(overrun), 0);
    ack();

    // R4
    phase = "R4";
    wr(2'd0, 16'h0003);
    conv(0, 2);
    rd(0, 0);
    chk("R4", "req after other-channel read", int'(dma_req), 1);
    rd(1, 2);
    chk("R4", "req after other-kind read", int'(dma_req), 1);
    rd(0, 2);
    chk("R4", "req after matching read", int'(dma_req), 0);
    conv(1, 15);
    ack();
    chk("R6", "ack in clear-on-read mode", int'(dma_req), 0);

    // R5
    phase = "R5";
    conv_busy = 1'b1;
    wr(2'd1, 16'hFFFF);
    conv_busy = 1'b0;
    conv(0, 1);
    chk("R5", "busy write ignored", int'(dma_req), 0);
    wr(2'd1, 16'h0002);
    conv(0, 1);
    chk("R5", "idle write taken", int'(dma_req), 1);

    // R3: disabling drops the request
    phase = "R3";
    conv(0, 1);
    wr(2'd0, 16'h0000);
    cyc();
    chk("R3", "req after disable", int'(dma_req), 0);
    chk("R3", "overrun after disable", int'(overrun), 0);
    conv(0, 1);
    chk("R3", "req stays off", int'(dma_req), 0);

    repeat (2) cyc();
    finish_run();
  end

endmodule